// File: doc/BRIEF.md
# Status Register and Write Permission Unit

This unit keeps the control and status byte of a serial non-volatile memory and judges every write the command decoder wants to start. The decoder reports write enable and write disable commands, presents a status byte it has received, marks the moment chip select returns high, and supplies the target byte address of an array or identification-page write. The unit answers with three permit lines (array, identification page, status byte) and the status byte for readback.

The permit lines weigh a write-enable latch, a hardware protect pin gated by a stored pin-enable bit, and a two-bit range that locks the upper quarter, the upper half or all of the array. A volatile select bit steers accesses to a small identification page. A lock bit, once set, keeps that page read-only for good. The stored bits are plain registers that a soft reset leaves alone. A committed write starts a busy interval of fixed length, and during it only readback is possible.

Top module: `wrprot_status`

## Requirements
- R1: `status_o` is packed MSB first as {pin-enable, page-select, 0, page-lock, range[1:0], write-latch, busy}, and bit 5 always reads 0.
- R2: A write-enable pulse sets the write latch (bit 1) at the next clock edge. A write-disable pulse clears it, and disable wins when both come together. Both are ignored while busy (bit 0) is 1.
- R3: The range field selects the protected part of the 15-bit array address: 00 protects nothing, 01 protects 0x6000-0x7FFF, 10 protects 0x4000-0x7FFF, and 11 protects every address. `arr_wr_ok_o` is 0 for a protected address.
- R4: `arr_wr_ok_o` needs write latch 1, busy 0 and page-select 0, and the address must be unprotected. An array commit clears the write latch and starts the busy interval.
- R5: `sr_wr_ok_o` is 1 exactly when the write latch is 1, busy is 0, and not both (pin-enable 1 and `wp_pin_i` low).
- R6: A committed status write changes only bits 7, 6, 4, 3 and 2, taking them from the received byte. It also clears the write latch and sets busy from the next edge on.
- R7: If the received byte has both bit 6 and bit 4 set, page-select and page-lock both stay unchanged, while bits 7, 3 and 2 are still written.
- R8: Once page-lock is 1, no status write clears it.
- R9: `ip_wr_ok_o` needs write latch 1, busy 0, page-select 1, page-lock 0 and range not 11, with the low 6 address bits as the page byte address.
- R10: Page-select clears at the edge that samples `ipl_used_i` or an accepted array commit.
- R11: If the status lock (pin-enable 1 and pin low) holds at any edge between acceptance of the status byte and the commit, that write is dropped. A pin drop after the commit has no effect on it.
- R12: Busy reads 1 for exactly WR_CYCLES clock cycles after a commit.
- R13: A synchronous reset clears the write latch, page-select, busy and any pending status write, and keeps pin-enable, page-lock and range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| wp_pin_i | input | 1 | Hardware protect pin, low means protect |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable command pulse |
| sr_data_valid_i | input | 1 | Received status byte is valid |
| sr_data_i | input | 8 | Received status byte |
| sr_commit_i | input | 1 | Chip select rose after a status write |
| arr_commit_i | input | 1 | Chip select rose after a permitted array or page write |
| ipl_used_i | input | 1 | A read or write through the page-select has finished |
| wr_addr_i | input | AW | Target byte address of the pending write |
| status_o | output | 8 | Status byte for readback |
| arr_wr_ok_o | output | 1 | Array write permitted |
| ip_wr_ok_o | output | 1 | Identification-page write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
Command pulses, status commits and resets show in `status_o` one clock edge after the edge that samples them. The busy bit stays high for WR_CYCLES sampled cycles after that. The three permit lines are combinational on the registered state, the pin and the address, so they are read in the same low clock phase in which the pin or address was changed, after a short settle. The bench drives inputs on the falling edge and samples on the next falling edge, so every registered result is read exactly one rising edge after its stimulus. Each busy interval is counted cycle by cycle and is not judged by a fixed wait.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
// Shared types and bit positions for the status/permission unit.
// Assumes an 8-bit status byte; positions here are decoded by neighbours.
package wp_pkg;
    localparam int SR_WPEN = 7;
    localparam int SR_IPL  = 6;
    localparam int SR_LIP  = 4;
    localparam int SR_BP1  = 3;
    localparam int SR_BP0  = 2;
    localparam int SR_WEL  = 1;
    localparam int SR_RDY  = 0;

    localparam logic [1:0] BP_NONE = 2'b00;
    localparam logic [1:0] BP_QTR  = 2'b01;
    localparam logic [1:0] BP_HALF = 2'b10;
    localparam logic [1:0] BP_FULL = 2'b11;

    // Stored (non-volatile model) bits.
    typedef struct packed {
        logic       wpen;
        logic       lip;
        logic [1:0] bp;
    } nv_bits_t;
endpackage

// File: rtl/wp_range_chk.sv
`timescale 1ns/1ps
// Decides whether an address lies inside the range chosen by the
// two-bit block-protect code. Assumes the range is always an upper
// quarter, upper half or whole space, so only the top two bits matter.
module wp_range_chk #(
    parameter int AW = 15
) (
    input  logic [1:0]    bp_i,
    input  logic [AW-1:0] addr_i,
    output logic          prot_o
);
    import wp_pkg::*;
    localparam int TOP = AW - 1;

    logic [1:0] quad;
    assign quad = addr_i[TOP -: 2];

    // Map code and address quadrant to the protected flag.
    always_comb begin
        unique case (bp_i)
            BP_NONE: prot_o = 1'b0;
            BP_QTR:  prot_o = (quad == 2'b11);
            BP_HALF: prot_o = quad[1];
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_cycle_timer.sv
`timescale 1ns/1ps
// Busy interval for the internal write cycle. A start pulse raises busy
// for exactly CYCLES clocks. Assumes no start arrives while busy.
module wp_cycle_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Load on start, count down, drop busy after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= LAST;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;

    assert_busy_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0 && !start_i) |=> !busy_q);
    assert_busy_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q);
endmodule

// File: rtl/wp_status_core.sv
`timescale 1ns/1ps
// Holds the write latch, page select, stored protection bits and a
// pending status write. Assumes the decoder gives single-cycle pulses and
// raises the commit lines only when chip select rises.
module wp_status_core
    import wp_pkg::*;
#(
    parameter logic [3:0] NV_INIT = 4'b0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_pin_i,
    input  logic       wren_i,
    input  logic       wrdi_i,
    input  logic       sr_valid_i,
    input  logic [7:0] sr_data_i,
    input  logic       sr_commit_i,
    input  logic       arr_commit_i,
    input  logic       ipl_used_i,
    input  logic       busy_i,
    output logic       wel_o,
    output logic       ipl_o,
    output nv_bits_t   nv_o,
    output logic       lock_o,
    output logic       start_o
);
    logic       wel_q, ipl_q, pend_q;
    logic [7:0] pend_d_q;
    nv_bits_t   nv_q = nv_bits_t'(NV_INIT);
    logic       lock, accept, apply, conflict, arr_go;

    assign lock     = nv_q.wpen && !wp_pin_i;
    assign accept   = sr_valid_i && wel_q && !busy_i && !lock;
    assign apply    = rst_n && sr_commit_i && pend_q && !lock && !busy_i;
    assign conflict = pend_d_q[SR_IPL] && pend_d_q[SR_LIP];
    assign arr_go   = arr_commit_i && !busy_i;

    // Write-enable latch: commits clear it, commands act only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wel_q <= 1'b0;
        else if (apply || arr_go)   wel_q <= 1'b0;
        else if (!busy_i && wrdi_i) wel_q <= 1'b0;
        else if (!busy_i && wren_i) wel_q <= 1'b1;
    end

    // Pending status byte between data capture and chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pend_d_q <= '0;
        end else if (accept) begin
            pend_q   <= 1'b1;
            pend_d_q <= sr_data_i;
        end else if (lock || sr_commit_i) begin
            pend_q   <= 1'b0;
        end
    end

    // Volatile page select: cleared when an access has used it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ipl_q <= 1'b0;
        else if (arr_go || ipl_used_i)  ipl_q <= 1'b0;
        else if (apply && !conflict)    ipl_q <= pend_d_q[SR_IPL];
    end

    // Stored bits: untouched by reset, lock bit is sticky.
    always_ff @(posedge clk) begin
        if (apply) begin
            nv_q.wpen <= pend_d_q[SR_WPEN];
            nv_q.bp   <= pend_d_q[SR_BP1:SR_BP0];
            if (!conflict) nv_q.lip <= nv_q.lip | pend_d_q[SR_LIP];
        end
    end

    assign wel_o   = wel_q;
    assign ipl_o   = ipl_q;
    assign nv_o    = nv_q;
    assign lock_o  = lock;
    assign start_o = apply || arr_go;

    assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_i && !wrdi_i && !busy_i && !sr_commit_i && !arr_commit_i) |=> wel_q);
    assert_wel_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrdi_i && !busy_i) |=> !wel_q);
    assert_nv_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_commit_i && pend_q) |=> $stable(nv_q));
    assert_lip_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q.lip |=> nv_q.lip);
    assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && lock && !accept) |=> !pend_q);
endmodule

// File: rtl/wrprot_status.sv
`timescale 1ns/1ps
// Status register and write-permission unit. Combines the write latch,
// protect pin, pin-enable bit, block range, page select and page lock
// into three permit lines. Assumes an AW-bit array address and a
// 64-byte identification page addressed by the low 6 bits.
module wrprot_status
    import wp_pkg::*;
#(
    parameter int         AW        = 15,
    parameter int         PAGE_AW   = 6,
    parameter int         WR_CYCLES = 8,
    parameter logic [3:0] NV_INIT   = 4'b0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp_pin_i,
    input  logic          wren_i,
    input  logic          wrdi_i,
    input  logic          sr_data_valid_i,
    input  logic [7:0]    sr_data_i,
    input  logic          sr_commit_i,
    input  logic          arr_commit_i,
    input  logic          ipl_used_i,
    input  logic [AW-1:0] wr_addr_i,
    output logic [7:0]    status_o,
    output logic          arr_wr_ok_o,
    output logic          ip_wr_ok_o,
    output logic          sr_wr_ok_o
);
    localparam int NCHK = 2;

    logic     busy, wel, ipl, lock, start;
    nv_bits_t nv;
    logic [AW-1:0] chk_addr [NCHK];
    logic [NCHK-1:0] prot;

    wp_status_core #(.NV_INIT(NV_INIT)) u_core (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i),
        .sr_valid_i(sr_data_valid_i), .sr_data_i(sr_data_i),
        .sr_commit_i(sr_commit_i), .arr_commit_i(arr_commit_i),
        .ipl_used_i(ipl_used_i), .busy_i(busy),
        .wel_o(wel), .ipl_o(ipl), .nv_o(nv), .lock_o(lock), .start_o(start)
    );

    wp_cycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy)
    );

    // Index 0 checks the array address, index 1 the page byte address.
    assign chk_addr[0] = wr_addr_i;
    assign chk_addr[1] = AW'(wr_addr_i[PAGE_AW-1:0]);

    generate
        for (genvar g = 0; g < NCHK; g++) begin : g_rng
            wp_range_chk #(.AW(AW)) u_rng (
                .bp_i(nv.bp), .addr_i(chk_addr[g]), .prot_o(prot[g])
            );
        end
    endgenerate

    // Readback byte in the fixed field order.
    assign status_o = {nv.wpen, ipl, 1'b0, nv.lip, nv.bp, wel, busy};

    // Permit decisions from registered state, pin and address.
    always_comb begin
        sr_wr_ok_o  = wel && !busy && !lock;
        arr_wr_ok_o = wel && !busy && !ipl && !prot[0];
        ip_wr_ok_o  = wel && !busy && ipl && !nv.lip && (nv.bp != BP_FULL) && !prot[1];
    end

    assert_full_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nv.bp == BP_FULL) |-> (!arr_wr_ok_o && !ip_wr_ok_o));
    assert_commit_drops_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_commit_i && !busy) |=> (!wel && busy));
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!sr_wr_ok_o && !arr_wr_ok_o && !ip_wr_ok_o));
    assert_lock_blocks_ip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nv.lip |-> !ip_wr_ok_o);
    assert_ipl_used_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_used_i |=> !ipl);
endmodule

// File: tb/wrprot_status_test.sv
`timescale 1ns/1ps
module wrprot_status_test;
    localparam int AW = 15;
    localparam int WR = 8;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst_n, wp_pin, wren, wrdi, srv, src, arc, iplu;
    logic [7:0] srd;
    logic [AW-1:0] addr;
    logic [7:0] status;
    logic arr_ok, ip_ok, sr_ok;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wrprot_status #(.AW(AW), .WR_CYCLES(WR)) uut (
        .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin), .wren_i(wren), .wrdi_i(wrdi),
        .sr_data_valid_i(srv), .sr_data_i(srd), .sr_commit_i(src),
        .arr_commit_i(arc), .ipl_used_i(iplu), .wr_addr_i(addr),
        .status_o(status), .arr_wr_ok_o(arr_ok), .ip_wr_ok_o(ip_ok), .sr_wr_ok_o(sr_ok)
    );

    // Range table: {bp[1:0], addr[14:0], expected array permit}
    localparam logic [17:0] VEC [NV] = '{
        {2'b00, 15'h0000, 1'b1}, {2'b00, 15'h7FFF, 1'b1},
        {2'b01, 15'h5FFF, 1'b1}, {2'b01, 15'h6000, 1'b0},
        {2'b01, 15'h7FFF, 1'b0}, {2'b01, 15'h0000, 1'b1},
        {2'b10, 15'h3FFF, 1'b1}, {2'b10, 15'h4000, 1'b0},
        {2'b10, 15'h6000, 1'b0}, {2'b11, 15'h0000, 1'b0},
        {2'b11, 15'h3FFF, 1'b0}, {2'b00, 15'h4000, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_wren();
        wren = 1; tick(); wren = 0;
    endtask

    task automatic sr_write(input logic [7:0] d);
        do_wren();
        srv = 1; srd = d; tick(); srv = 0;
        src = 1; tick(); src = 0;
        tick(WR);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wp_pin = 1; wren = 0; wrdi = 0; srv = 0; src = 0;
        arc = 0; iplu = 0; srd = 0; addr = 0;
        tick(3); rst_n = 1; tick();
        chk("R13 reset status", status, 8'h00);

        // R2 latch commands
        do_wren();
        chk("R2 wren sets latch", status, 8'h02);
        chk("R1 bit5 zero", status[5], 1'b0);
        wrdi = 1; tick(); wrdi = 0;
        chk("R2 wrdi clears", status, 8'h00);
        wren = 1; wrdi = 1; tick(); wren = 0; wrdi = 0;
        chk("R2 disable wins", status, 8'h00);
        do_wren();
        arc = 1; tick(); arc = 0;
        chk("R4 array commit busy no latch", status, 8'h01);
        do_wren();
        chk("R2 wren ignored busy", status[1], 1'b0);
        tick(WR);

        // R5 pin ignored with pin-enable 0
        do_wren(); wp_pin = 0; #1;
        chk("R5 pin ignored wpen0", sr_ok, 1'b1);
        wp_pin = 1;
        wrdi = 1; tick(); wrdi = 0;

        // R3 range table
        for (int v = 0; v < NV; v++) begin
            sr_write({4'b0000, VEC[v][17:16], 2'b00});
            do_wren();
            addr = VEC[v][15:1]; #1;
            chk($sformatf("R3 range vec %0d", v), arr_ok, VEC[v][0]);
        end
        wrdi = 1; tick(); wrdi = 0;

        // R6 / R12 writable bits and busy length
        do_wren();
        srv = 1; srd = 8'h2F; tick(); srv = 0;
        src = 1; tick(); src = 0;
        chk("R6 commit image", status, 8'h0D);
        begin
            int cnt = 0;
            for (int i = 0; i < 3 * WR; i++) begin
                if (status[0]) cnt++;
                tick();
            end
            chk("R12 busy length", cnt, WR);
        end
        chk("R6 only writable bits", status, 8'h0C);

        // R7 conflict
        sr_write(8'h54);
        chk("R7 conflict keeps ipl lip", status, 8'h04);

        // R9 / R10 page select
        sr_write(8'h40);
        chk("R6 page select set", status, 8'h40);
        do_wren(); addr = 15'h0005; #1;
        chk("R9 page permit", ip_ok, 1'b1);
        chk("R4 array denied by select", arr_ok, 1'b0);
        iplu = 1; tick(); iplu = 0;
        chk("R10 used clears select", status, 8'h02);
        chk("R9 page denied no select", ip_ok, 1'b0);
        sr_write(8'h4C);
        do_wren(); #1;
        chk("R9 page denied full range", ip_ok, 1'b0);
        arc = 1; tick(); arc = 0;
        chk("R10 commit clears select", status, 8'h0D);
        tick(WR);

        // R11 cancel and late pin drop
        sr_write(8'h80);
        chk("R6 pin-enable set", status, 8'h80);
        do_wren(); wp_pin = 0; #1;
        chk("R5 locked by pin", sr_ok, 1'b0);
        wp_pin = 1; #1;
        chk("R5 pin high allows", sr_ok, 1'b1);
        srv = 1; srd = 8'h88; tick(); srv = 0;
        wp_pin = 0; tick(); wp_pin = 1;
        src = 1; tick(); src = 0;
        chk("R11 cancelled write", status, 8'h82);
        srv = 1; srd = 8'h84; tick(); srv = 0;
        src = 1; tick(); src = 0; wp_pin = 0;
        chk("R11 late drop applied", status, 8'h85);
        tick(WR); wp_pin = 1;
        chk("R11 after cycle", status, 8'h84);

        // R13 reset keeps stored bits
        sr_write(8'hC4);
        do_wren();
        chk("R13 pre reset", status, 8'hC6);
        rst_n = 0; tick(); rst_n = 1;
        chk("R13 reset keeps stored", status, 8'h84);
        do_wren(); arc = 1; tick(); arc = 0;
        chk("R13 busy before reset", status, 8'h85);
        rst_n = 0; tick(); rst_n = 1;
        chk("R13 reset clears busy", status, 8'h84);

        // R8 sticky lock (last: cannot be undone)
        sr_write(8'h10);
        chk("R8 lock set", status, 8'h10);
        sr_write(8'h00);
        chk("R8 lock sticky", status, 8'h10);
        sr_write(8'h40);
        chk("R8 select with lock", status, 8'h50);
        do_wren(); addr = 15'h0005; #1;
        chk("R9 page denied by lock", ip_ok, 1'b0);

        done = 1;
        summary();
        $finish;
    end
endmodule